// File: doc/BRIEF.md
# Shortest-Path Relaxation Node Element

This block is the per-node worker of a distributed single-source shortest-path engine. Many identical copies run side by side in lockstep. They talk over one shared broadcast bus, and no central sequencer exists. Each copy holds the best-known cost from the chosen source to its own node, the predecessor on that path, and a small table of incoming links. Each link entry gives a start node and a weight.

A computation begins with a start pulse that carries the source index. Time is then split into iterations of `N_NODES + 1` cycles. In slot k, element k places its cost and a "changed last iteration" bit on the bus. Every element registers the bus, so data from slot k is seen in slot k+1. On that cycle each element compares the implied sender index with all of its table entries at once. It adds the link weight to the received cost, saturating at the infinity code. If the result is strictly smaller than the stored cost, it adopts the result and records the sender as its predecessor.

Each element keeps watch for raised changed bits. When a whole iteration passes with none, every element stops in the same cycle. The source element then holds a completion marker on the bus. The bus is time-slotted by construction, so there is no valid/ready handshake and no back-pressure. Every pin is a plain control or data level.

Top module: `spe_node`

## Requirements
- R1: On an accepted start, the element whose `node_i` equals `src_i` sets its cost to 0. Every other element sets its cost to infinity, the all-ones value of `COST_W` bits. Every element sets its predecessor to its own index.
- R2: An iteration lasts `N_NODES+1` cycles, with the slot counter running from 0 to `N_NODES`. Element k asserts `bus_oe_o` while computing only in slot k, so at most one element drives at a time and none drives in slot `N_NODES`.
- R3: After completion, each element's cost equals the least sum of link weights from the source, and the predecessor names a start node of a tight incoming link (predecessor cost + weight = own cost). During a run, a cost never rises, and the predecessor changes only together with the cost.
- R4: When several table entries share the same start node, the smallest candidate among them is taken in the same cycle.
- R5: Sums are formed one bit wider and clamp to infinity. A node whose true distance is at least infinity reports infinity and keeps its own index as predecessor.
- R6: All elements raise `done_o` in the same cycle, exactly k·(`N_NODES`+1) cycles after the start edge, with k ≥ 2. The run ends after the first iteration in which no broadcast changed bit was seen. `busy_o` and `done_o` are never high together.
- R7: After completion, only the source element drives the bus. It asserts `bus_oe_o` and `bus_fin_o` together, and `bus_fin_o` is never high anywhere else.
- R8: After reset, the element is idle. `busy_o`, `done_o` and `bus_oe_o` are low, and the cost is infinity.
- R9: A node with no path from the source keeps cost infinity and its own index as predecessor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; accepted when not busy |
| src_i | input | IDX_W | Source node index, sampled with start |
| node_i | input | IDX_W | This element's own index |
| lnk_vld_i | input | DEG | Valid bit for each incoming-link entry |
| lnk_src_i | input | DEG*IDX_W | Start node of each entry, entry k at bits [k*IDX_W +: IDX_W] |
| lnk_wt_i | input | DEG*WT_W | Weight of each entry, entry k at bits [k*WT_W +: WT_W] |
| bus_oe_i | input | 1 | Shared bus: some element is driving |
| bus_cost_i | input | COST_W | Shared bus: broadcast cost |
| bus_chg_i | input | 1 | Shared bus: broadcast changed bit |
| bus_oe_o | output | 1 | This element drives the bus |
| bus_cost_o | output | COST_W | Cost driven (zero when not in own slot) |
| bus_chg_o | output | 1 | Changed-last-iteration bit driven in own slot |
| bus_fin_o | output | 1 | Completion marker, source element only |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | Computation converged |
| cost_o | output | COST_W | Current best cost |
| pred_o | output | IDX_W | Current predecessor index |

## Verification
The properties assume that start is raised only while the element is idle or finished. They also assume that the link table, the source and the node index stay fixed during a run, and that the shared bus is the OR of all element outputs. The bench builds an array of eight elements with a wired-OR bus. It changes the graph and the source only between runs, after completion. It sweeps every source over chain, reverse-chain, duplicate-link, empty and pseudo-random graphs. The expected distances come from a saturating relaxation computed in the bench. The bench also checks that the completion time is a whole number of iterations.

// File: rtl/spe_pkg.sv
package spe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } spe_state_e;
endpackage

// File: rtl/spe_slot_ctr.sv
module spe_slot_ctr #(
  parameter int N_NODES = 8,
  localparam int SLOT_W = $clog2(N_NODES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              run_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              last_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(N_NODES);

  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          slot_q <= '0;
    else if (clear_i)    slot_q <= '0;
    else if (run_i)      slot_q <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
  end

  assign slot_o = slot_q;
  assign last_o = (slot_q == LAST);
endmodule

// File: rtl/spe_relax.sv
module spe_relax #(
  parameter int DEG    = 4,
  parameter int IDX_W  = 3,
  parameter int WT_W   = 8,
  parameter int COST_W = 12
) (
  input  logic                  en_i,
  input  logic [IDX_W-1:0]      sender_i,
  input  logic [COST_W-1:0]     rx_cost_i,
  input  logic [COST_W-1:0]     cur_cost_i,
  input  logic [DEG-1:0]        lnk_vld_i,
  input  logic [DEG*IDX_W-1:0]  lnk_src_i,
  input  logic [DEG*WT_W-1:0]   lnk_wt_i,
  output logic                  upd_o,
  output logic [COST_W-1:0]     best_o
);
  localparam int SUM_W = COST_W + 1;
  localparam logic [COST_W-1:0] INF = '1;
  localparam logic [SUM_W-1:0]  INF_W = {1'b0, INF};

  logic [DEG-1:0]    hit;
  logic [COST_W-1:0] cand [DEG];

  for (genvar k = 0; k < DEG; k++) begin : g_ent
    logic [SUM_W-1:0] sum;
    assign sum     = {1'b0, rx_cost_i} + SUM_W'(lnk_wt_i[k*WT_W +: WT_W]);
    assign hit[k]  = lnk_vld_i[k] && (lnk_src_i[k*IDX_W +: IDX_W] == sender_i);
    assign cand[k] = (sum >= INF_W) ? INF : sum[COST_W-1:0];
  end

  always_comb begin
    best_o = INF;
    for (int k = 0; k < DEG; k++) begin
      if (hit[k] && (cand[k] < best_o)) best_o = cand[k];
    end
    upd_o = en_i && (best_o < cur_cost_i);
  end
endmodule

// File: rtl/spe_conv.sv
module spe_conv (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic src_init_i,
  input  logic run_i,
  input  logic last_i,
  input  logic flag_i,
  input  logic upd_i,
  output logic chg_prev_o,
  output logic stop_o
);
  logic seen_q, cur_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      cur_q  <= 1'b0;
      prev_q <= 1'b0;
    end else if (clear_i) begin
      seen_q <= 1'b0;
      cur_q  <= 1'b0;
      prev_q <= src_init_i;
    end else if (run_i) begin
      if (last_i) begin
        seen_q <= 1'b0;
        cur_q  <= 1'b0;
        prev_q <= cur_q | upd_i;
      end else begin
        seen_q <= seen_q | flag_i;
        cur_q  <= cur_q | upd_i;
      end
    end
  end

  assign chg_prev_o = prev_q;
  assign stop_o     = run_i && last_i && !(seen_q || flag_i);
endmodule

// File: rtl/spe_node.sv
module spe_node
  import spe_pkg::*;
#(
  parameter int N_NODES = 8,
  parameter int DEG     = 4,
  parameter int WT_W    = 8,
  parameter int COST_W  = 12,
  localparam int IDX_W  = $clog2(N_NODES),
  localparam int SLOT_W = $clog2(N_NODES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [IDX_W-1:0]     src_i,
  input  logic [IDX_W-1:0]     node_i,
  input  logic [DEG-1:0]       lnk_vld_i,
  input  logic [DEG*IDX_W-1:0] lnk_src_i,
  input  logic [DEG*WT_W-1:0]  lnk_wt_i,
  input  logic                 bus_oe_i,
  input  logic [COST_W-1:0]    bus_cost_i,
  input  logic                 bus_chg_i,
  output logic                 bus_oe_o,
  output logic [COST_W-1:0]    bus_cost_o,
  output logic                 bus_chg_o,
  output logic                 bus_fin_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [COST_W-1:0]    cost_o,
  output logic [IDX_W-1:0]     pred_o
);
  localparam logic [COST_W-1:0] INF = '1;

  spe_state_e        state_q;
  logic [COST_W-1:0] cost_q;
  logic [IDX_W-1:0]  pred_q;
  logic              is_src_q;
  logic              rx_oe_q, rx_chg_q;
  logic [COST_W-1:0] rx_cost_q;

  logic              run, go, last, upd, stop, chg_prev, rx_live, drive;
  logic [SLOT_W-1:0] slot_q;
  logic [IDX_W-1:0]  sender;
  logic [COST_W-1:0] best;

  assign run     = (state_q == ST_RUN);
  assign go      = start_i && !run;
  assign rx_live = run && (slot_q != '0) && rx_oe_q;
  assign sender  = IDX_W'(slot_q - 1'b1);
  assign drive   = run && (slot_q == SLOT_W'(node_i));

  spe_slot_ctr #(.N_NODES(N_NODES)) u_slot (
    .clk(clk), .rst_n(rst_n), .clear_i(go), .run_i(run),
    .slot_o(slot_q), .last_o(last)
  );

  spe_relax #(.DEG(DEG), .IDX_W(IDX_W), .WT_W(WT_W), .COST_W(COST_W)) u_relax (
    .en_i(rx_live), .sender_i(sender), .rx_cost_i(rx_cost_q), .cur_cost_i(cost_q),
    .lnk_vld_i(lnk_vld_i), .lnk_src_i(lnk_src_i), .lnk_wt_i(lnk_wt_i),
    .upd_o(upd), .best_o(best)
  );

  spe_conv u_conv (
    .clk(clk), .rst_n(rst_n), .clear_i(go), .src_init_i(src_i == node_i),
    .run_i(run), .last_i(last), .flag_i(rx_live && rx_chg_q), .upd_i(upd),
    .chg_prev_o(chg_prev), .stop_o(stop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cost_q    <= INF;
      pred_q    <= '0;
      is_src_q  <= 1'b0;
      rx_oe_q   <= 1'b0;
      rx_chg_q  <= 1'b0;
      rx_cost_q <= '0;
    end else begin
      rx_oe_q   <= bus_oe_i;
      rx_chg_q  <= bus_chg_i;
      rx_cost_q <= bus_cost_i;
      if (go) begin
        state_q  <= ST_RUN;
        is_src_q <= (src_i == node_i);
        cost_q   <= (src_i == node_i) ? '0 : INF;
        pred_q   <= node_i;
      end else if (run) begin
        if (upd) begin
          cost_q <= best;
          pred_q <= sender;
        end
        if (stop) state_q <= ST_DONE;
      end
    end
  end

  assign busy_o     = run;
  assign done_o     = (state_q == ST_DONE);
  assign bus_fin_o  = done_o && is_src_q;
  assign bus_oe_o   = drive || bus_fin_o;
  assign bus_cost_o = drive ? cost_q : '0;
  assign bus_chg_o  = drive && chg_prev;
  assign cost_o     = cost_q;
  assign pred_o     = pred_q;
endmodule

// File: rtl/spe_node_chk.sv
module spe_node_chk #(
  parameter int N_NODES = 8,
  parameter int COST_W  = 12,
  parameter int IDX_W   = 3,
  parameter int SLOT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [IDX_W-1:0]  src_i,
  input logic [IDX_W-1:0]  node_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [COST_W-1:0] cost_o,
  input logic [IDX_W-1:0]  pred_o,
  input logic              bus_oe_o,
  input logic              bus_fin_o,
  input logic [SLOT_W-1:0] slot_q,
  input logic              is_src_q
);
  localparam logic [COST_W-1:0] INF = '1;

  a_r1_start_init: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_i && !busy_o) |-> (cost_o == ($past(src_i == node_i) ? {COST_W{1'b0}} : INF)));

  a_r2_own_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe_o && busy_o) |-> (slot_q == SLOT_W'(node_i)));

  a_r2_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= SLOT_W'(N_NODES));

  a_r3_cost_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> (cost_o <= $past(cost_o)));

  a_r3_pred_with_cost: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && (cost_o == $past(cost_o))) |-> (pred_o == $past(pred_o)));

  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));

  a_r7_fin_source: assert property (@(posedge clk) disable iff (!rst_n)
    bus_fin_o |-> (done_o && is_src_q && bus_oe_o));
endmodule

bind spe_node spe_node_chk #(
  .N_NODES(N_NODES), .COST_W(COST_W), .IDX_W(IDX_W), .SLOT_W(SLOT_W)
) u_spe_node_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .src_i(src_i), .node_i(node_i),
  .busy_o(busy_o), .done_o(done_o), .cost_o(cost_o), .pred_o(pred_o),
  .bus_oe_o(bus_oe_o), .bus_fin_o(bus_fin_o), .slot_q(slot_q), .is_src_q(is_src_q)
);

// File: tb/test_spe_node.sv
module test_spe_node;
  localparam int N   = 8;
  localparam int DEG = 4;
  localparam int WT  = 8;
  localparam int CW  = 10;
  localparam int IW  = 3;
  localparam int INF = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [IW-1:0] src = '0;
  logic [DEG-1:0]    lv [N];
  logic [DEG*IW-1:0] ls [N];
  logic [DEG*WT-1:0] lw [N];

  logic [N-1:0] oe, chg, fin, busy, done;
  logic [CW-1:0] bcost [N];
  logic [CW-1:0] cost  [N];
  logic [IW-1:0] pred  [N];
  logic bus_oe, bus_chg;
  logic [CW-1:0] bus_cost;

  int nchk = 0, nfail = 0;
  int gcnt [N];
  int gu [N][DEG];
  int gw [N][DEG];
  int expd [N];
  int unsigned seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  always_comb begin
    bus_oe = |oe;
    bus_chg = |chg;
    bus_cost = '0;
    for (int k = 0; k < N; k++) bus_cost = bus_cost | bcost[k];
  end

  for (genvar g = 0; g < N; g++) begin : g_pe
    spe_node #(.N_NODES(N), .DEG(DEG), .WT_W(WT), .COST_W(CW)) i_spe_node (
      .clk(clk), .rst_n(rst_n), .start_i(start), .src_i(src), .node_i(IW'(g)),
      .lnk_vld_i(lv[g]), .lnk_src_i(ls[g]), .lnk_wt_i(lw[g]),
      .bus_oe_i(bus_oe), .bus_cost_i(bus_cost), .bus_chg_i(bus_chg),
      .bus_oe_o(oe[g]), .bus_cost_o(bcost[g]), .bus_chg_o(chg[g]), .bus_fin_o(fin[g]),
      .busy_o(busy[g]), .done_o(done[g]), .cost_o(cost[g]), .pred_o(pred[g])
    );
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed >> 16);
  endfunction

  task automatic clear_graph();
    for (int v = 0; v < N; v++) begin
      gcnt[v] = 0;
      lv[v] = '0;
      ls[v] = '0;
      lw[v] = '0;
    end
  endtask

  task automatic add_link(input int u, input int v, input int w);
    int k;
    k = gcnt[v];
    if (k < DEG) begin
      gu[v][k] = u;
      gw[v][k] = w;
      lv[v][k] = 1'b1;
      ls[v][k*IW +: IW] = IW'(u);
      lw[v][k*WT +: WT] = WT'(w);
      gcnt[v] = k + 1;
    end
  endtask

  task automatic reference(input int s);
    for (int v = 0; v < N; v++) expd[v] = (v == s) ? 0 : INF;
    for (int it = 0; it < N; it++)
      for (int v = 0; v < N; v++)
        for (int k = 0; k < gcnt[v]; k++) begin
          int c;
          c = expd[gu[v][k]] + gw[v][k];
          if (c > INF) c = INF;
          if (c < expd[v]) expd[v] = c;
        end
  endtask

  task automatic run_case(input int s, input string tag);
    int cyc;
    bit multi;
    reference(s);
    @(negedge clk);
    src = IW'(s);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int v = 0; v < N; v++) begin
      chk(cost[v] == ((v == s) ? 0 : INF), "R1", "initial cost", int'(cost[v]), (v == s) ? 0 : INF);
      chk(pred[v] == IW'(v), "R1", "initial pred", int'(pred[v]), v);
    end
    cyc = 0;
    multi = 1'b0;
    while (done == '0 && cyc < 400) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if ($countones(oe) > 1) multi = 1'b1;
    end
    chk(!multi, "R2", "single bus driver", int'(multi), 0);
    chk(done == {N{1'b1}}, "R6", "all done together", int'(done), (1 << N) - 1);
    chk(cyc % (N + 1) == 0 && cyc >= 2 * (N + 1), "R6", "cycles to done", cyc, (N + 1) * (cyc / (N + 1)));
    chk(oe == N'(1 << s) && fin == N'(1 << s), "R7", "completion driver", int'(fin), 1 << s);
    for (int v = 0; v < N; v++) begin
      chk(int'(cost[v]) == expd[v], (expd[v] == INF) ? "R9" : tag, "final cost", int'(cost[v]), expd[v]);
      if (expd[v] == INF || v == s) begin
        chk(pred[v] == IW'(v), (v == s) ? "R1" : "R5", "pred self", int'(pred[v]), v);
      end else begin
        bit ok;
        int first;
        ok = 1'b0;
        first = -1;
        for (int k = 0; k < gcnt[v]; k++) begin
          if (expd[gu[v][k]] + gw[v][k] == expd[v]) begin
            if (first < 0) first = gu[v][k];
            if (int'(pred[v]) == gu[v][k]) ok = 1'b1;
          end
        end
        chk(ok, "R3", "tight predecessor", int'(pred[v]), first);
      end
    end
  endtask

  task automatic sweep(input string tag);
    for (int s = 0; s < N; s++) run_case(s, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R6 watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    clear_graph();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == '0, "R8", "busy after reset", int'(busy), 0);
    chk(done == '0, "R8", "done after reset", int'(done), 0);
    chk(oe == '0, "R8", "bus idle after reset", int'(oe), 0);
    for (int v = 0; v < N; v++) chk(cost[v] == CW'(INF), "R8", "cost after reset", int'(cost[v]), INF);

    // R5: forward chain of heavy links; paths beyond four hops clamp
    clear_graph();
    for (int v = 1; v < N; v++) add_link(v - 1, v, 255);
    sweep("R5");

    // R3: reverse chain, many iterations for low sources
    clear_graph();
    for (int v = 0; v < N - 1; v++) add_link(v + 1, v, 3);
    add_link(0, N - 1, 100);
    sweep("R3");

    // R4: duplicate entries from the same start node
    clear_graph();
    for (int v = 0; v < N; v++) begin
      add_link((v + 1) % N, v, 50);
      add_link((v + 3) % N, v, 20);
      add_link((v + 1) % N, v, 7);
    end
    sweep("R4");

    // R9: no links at all
    clear_graph();
    sweep("R9");

    // R3: pseudo-random graphs including zero weights
    for (int g = 0; g < 3; g++) begin
      clear_graph();
      for (int v = 0; v < N; v++)
        for (int k = 0; k < DEG; k++) begin
          if (rnd() % 4 != 0) begin
            int w;
            w = rnd() % 256;
            if (rnd() % 5 == 0) w = 0;
            add_link(rnd() % N, v, w);
          end
        end
      sweep("R3");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule